// File: doc/BRIEF.md
# Time Register Number-Format Converter

This block sits between a CPU-facing register port and the time-of-day and day-of-month counters of a real-time clock. The counters always hold plain binary. A runtime format bit chooses how the CPU sees them. When the bit is set, each field is shown as packed BCD with two digits per byte. When it is clear, each field is shown as a narrow binary value in fixed bit positions, and every other bit is zero.

Reads are combinational. The register selected by the read address is packed, and converted if needed, in the same cycle. Writes are decoded using the format that is active on the write cycle. A BCD write is converted to binary and checked before it is used. An accepted write gives a one-cycle update strobe to the counter side, together with the binary value to load. A write that is rejected gives no strobe, so the counter keeps its current value.

The register address selects the combined hour/minute register, the seconds register, the day register, or a reserved slot.

Top module: `tv_bcd_view`

## Requirements
- R1: While reset is held, and after it is released with no write, all update strobes and all binary output values are zero.
- R2: With the format bit clear, a read of address 0 returns hours in bits 12:8 and minutes in bits 5:0. Bits 15:13 and 7:6 are zero.
- R3: With the format bit set, a read of address 0 returns hours as two BCD digits in bits 15:8 (tens digit in 15:12) and minutes as two BCD digits in bits 7:0.
- R4: A read of address 1 (seconds) or address 2 (day) returns a binary value with the format bit clear (seconds in bits 5:0, day in bits 4:0) and two BCD digits in bits 7:0 with the format bit set. All higher bits are zero.
- R5: Read data follows the counter inputs, the address and the format bit in the same cycle, with no register on the path.
- R6: An accepted write raises the strobe of the addressed register in the cycle after the write, with the converted binary value alongside it.
- R7: With the format bit clear, a write takes only the binary field bits (hours 12:8 and minutes 5:0 at address 0, bits 5:0 at address 1, bits 4:0 at address 2). All other bits are ignored.
- R8: A BCD write with any used nibble above 9 is rejected: no strobe is raised and the output values hold.
- R9: A write whose value is out of range is rejected in either format. The limits are hours above 23, minutes or seconds above 59, and day 0 or above 31.
- R10: Address 3 is reserved. It reads as zero, and writes to it raise no strobe.
- R11: At most one strobe is high in a cycle. A single write gives a strobe exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bcd_en_i | input | 1 | Format select: 1 = packed BCD, 0 = binary |
| rd_addr_i | input | 2 | Read register select |
| rd_data_o | output | 16 | Read data in the selected format |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | 2 | Write register select |
| wr_data_i | input | 16 | Write data in the selected format |
| hour_i | input | 5 | Current hour count (binary) |
| min_i | input | 6 | Current minute count (binary) |
| sec_i | input | 6 | Current second count (binary) |
| day_i | input | 5 | Current day count (binary) |
| upd_hm_o | output | 1 | Load strobe for the hour and minute counters |
| upd_sec_o | output | 1 | Load strobe for the second counter |
| upd_day_o | output | 1 | Load strobe for the day counter |
| new_hour_o | output | 5 | Hour value to load |
| new_min_o | output | 6 | Minute value to load |
| new_sec_o | output | 6 | Second value to load |
| new_day_o | output | 5 | Day value to load |

## Verification
A read and a write can fall in the same cycle, and they can target the same register. To provoke this, the bench holds the read address on the hour/minute register and issues a BCD write to it in the same cycle. It then checks that the read data still shows the counter inputs converted to BCD in that cycle. In the next cycle it checks that the update strobe and the new binary values appear. The same write is then repeated with the format bit cleared, to confirm that the decode follows the format in force on the write cycle.

// File: rtl/tv_pkg.sv
`timescale 1ns/1ps
package tv_pkg;
  localparam int DATA_W = 16;
  localparam int HOUR_W = 5;
  localparam int MIN_W  = 6;
  localparam int SEC_W  = 6;
  localparam int DAY_W  = 5;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_HM   = 2'd0,
    REG_SEC  = 2'd1,
    REG_DAY  = 2'd2,
    REG_RSVD = 2'd3
  } tv_reg_e;

  function automatic logic in_rng(input logic [7:0] v, input logic [7:0] lo,
                                  input logic [7:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/tv_bin2bcd.sv
`timescale 1ns/1ps
module tv_bin2bcd #(
  parameter int W = 6
) (
  input  logic [W-1:0] bin_i,
  output logic [7:0]   bcd_o
);
  logic [7:0] v;
  always_comb begin
    v     = 8'(bin_i);
    bcd_o = {4'(v / 8'd10), 4'(v % 8'd10)};
  end
endmodule

// File: rtl/tv_bcd2bin.sv
`timescale 1ns/1ps
module tv_bcd2bin #(
  parameter int W  = 6,
  parameter int LO = 0,
  parameter int HI = 59
) (
  input  logic [7:0]   bcd_i,
  output logic [W-1:0] bin_o,
  output logic         ok_o
);
  import tv_pkg::*;
  logic [7:0] val;
  logic       digits_ok;
  always_comb begin
    val       = {4'b0, bcd_i[7:4]} * 8'd10 + {4'b0, bcd_i[3:0]};
    digits_ok = (bcd_i[7:4] <= 4'd9) && (bcd_i[3:0] <= 4'd9);
    ok_o      = digits_ok && in_rng(val, 8'(LO), 8'(HI));
    bin_o     = val[W-1:0];
  end
endmodule

// File: rtl/tv_rd_view.sv
`timescale 1ns/1ps
module tv_rd_view
  import tv_pkg::*;
(
  input  logic                  bcd_en_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  input  logic [HOUR_W-1:0]     hour_i,
  input  logic [MIN_W-1:0]      min_i,
  input  logic [SEC_W-1:0]      sec_i,
  input  logic [DAY_W-1:0]      day_i,
  output logic [DATA_W-1:0]     rd_data_o
);
  localparam int BYTE_W = 8;

  logic [7:0] hour_bcd, min_bcd, sec_bcd, day_bcd;
  logic [DATA_W-1:0] hm_v, sec_v, day_v;

  tv_bin2bcd #(.W(HOUR_W)) u_hour (.bin_i(hour_i), .bcd_o(hour_bcd));
  tv_bin2bcd #(.W(MIN_W))  u_min  (.bin_i(min_i),  .bcd_o(min_bcd));
  tv_bin2bcd #(.W(SEC_W))  u_sec  (.bin_i(sec_i),  .bcd_o(sec_bcd));
  tv_bin2bcd #(.W(DAY_W))  u_day  (.bin_i(day_i),  .bcd_o(day_bcd));

  always_comb begin
    hm_v  = '0;
    sec_v = '0;
    day_v = '0;
    if (bcd_en_i) begin
      hm_v[BYTE_W +: BYTE_W] = hour_bcd;
      hm_v[0 +: BYTE_W]      = min_bcd;
      sec_v[0 +: BYTE_W]     = sec_bcd;
      day_v[0 +: BYTE_W]     = day_bcd;
    end else begin
      hm_v[BYTE_W +: HOUR_W] = hour_i;
      hm_v[0 +: MIN_W]       = min_i;
      sec_v[0 +: SEC_W]      = sec_i;
      day_v[0 +: DAY_W]      = day_i;
    end
  end

  always_comb begin
    unique case (tv_reg_e'(rd_addr_i))
      REG_HM:  rd_data_o = hm_v;
      REG_SEC: rd_data_o = sec_v;
      REG_DAY: rd_data_o = day_v;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/tv_wr_path.sv
`timescale 1ns/1ps
module tv_wr_path
  import tv_pkg::*;
#(
  parameter int HOUR_MAX = 23,
  parameter int MIN_MAX  = 59,
  parameter int SEC_MAX  = 59,
  parameter int DAY_MIN  = 1,
  parameter int DAY_MAX  = 31
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bcd_en_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  output logic                  upd_hm_o,
  output logic                  upd_sec_o,
  output logic                  upd_day_o,
  output logic [HOUR_W-1:0]     new_hour_o,
  output logic [MIN_W-1:0]      new_min_o,
  output logic [SEC_W-1:0]      new_sec_o,
  output logic [DAY_W-1:0]      new_day_o
);
  localparam int BYTE_W = 8;

  // BCD decode of both bytes
  logic [HOUR_W-1:0] b_hour;
  logic [MIN_W-1:0]  b_min;
  logic [SEC_W-1:0]  b_sec;
  logic [DAY_W-1:0]  b_day;
  logic b_hour_ok, b_min_ok, b_sec_ok, b_day_ok;

  tv_bcd2bin #(.W(HOUR_W), .LO(0), .HI(HOUR_MAX)) u_hour (
    .bcd_i(wr_data_i[BYTE_W +: BYTE_W]), .bin_o(b_hour), .ok_o(b_hour_ok));
  tv_bcd2bin #(.W(MIN_W), .LO(0), .HI(MIN_MAX)) u_min (
    .bcd_i(wr_data_i[0 +: BYTE_W]), .bin_o(b_min), .ok_o(b_min_ok));
  tv_bcd2bin #(.W(SEC_W), .LO(0), .HI(SEC_MAX)) u_sec (
    .bcd_i(wr_data_i[0 +: BYTE_W]), .bin_o(b_sec), .ok_o(b_sec_ok));
  tv_bcd2bin #(.W(DAY_W), .LO(DAY_MIN), .HI(DAY_MAX)) u_day (
    .bcd_i(wr_data_i[0 +: BYTE_W]), .bin_o(b_day), .ok_o(b_day_ok));

  // binary field extraction, unused bits dropped
  logic [HOUR_W-1:0] n_hour;
  logic [MIN_W-1:0]  n_min;
  logic [SEC_W-1:0]  n_sec;
  logic [DAY_W-1:0]  n_day;
  logic n_hour_ok, n_min_ok, n_sec_ok, n_day_ok;

  always_comb begin
    n_hour    = wr_data_i[BYTE_W +: HOUR_W];
    n_min     = wr_data_i[0 +: MIN_W];
    n_sec     = wr_data_i[0 +: SEC_W];
    n_day     = wr_data_i[0 +: DAY_W];
    n_hour_ok = in_rng(8'(n_hour), 8'd0, 8'(HOUR_MAX));
    n_min_ok  = in_rng(8'(n_min), 8'd0, 8'(MIN_MAX));
    n_sec_ok  = in_rng(8'(n_sec), 8'd0, 8'(SEC_MAX));
    n_day_ok  = in_rng(8'(n_day), 8'(DAY_MIN), 8'(DAY_MAX));
  end

  logic [HOUR_W-1:0] s_hour;
  logic [MIN_W-1:0]  s_min;
  logic [SEC_W-1:0]  s_sec;
  logic [DAY_W-1:0]  s_day;
  logic acc_hm, acc_sec, acc_day;

  always_comb begin
    s_hour  = bcd_en_i ? b_hour : n_hour;
    s_min   = bcd_en_i ? b_min  : n_min;
    s_sec   = bcd_en_i ? b_sec  : n_sec;
    s_day   = bcd_en_i ? b_day  : n_day;
    acc_hm  = wr_en_i && (tv_reg_e'(wr_addr_i) == REG_HM) &&
              (bcd_en_i ? (b_hour_ok && b_min_ok) : (n_hour_ok && n_min_ok));
    acc_sec = wr_en_i && (tv_reg_e'(wr_addr_i) == REG_SEC) &&
              (bcd_en_i ? b_sec_ok : n_sec_ok);
    acc_day = wr_en_i && (tv_reg_e'(wr_addr_i) == REG_DAY) &&
              (bcd_en_i ? b_day_ok : n_day_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_hm_o   <= 1'b0;
      upd_sec_o  <= 1'b0;
      upd_day_o  <= 1'b0;
      new_hour_o <= '0;
      new_min_o  <= '0;
      new_sec_o  <= '0;
      new_day_o  <= '0;
    end else begin
      upd_hm_o  <= acc_hm;
      upd_sec_o <= acc_sec;
      upd_day_o <= acc_day;
      if (acc_hm) begin
        new_hour_o <= s_hour;
        new_min_o  <= s_min;
      end
      if (acc_sec) new_sec_o <= s_sec;
      if (acc_day) new_day_o <= s_day;
    end
  end
endmodule

// File: rtl/tv_bcd_view.sv
`timescale 1ns/1ps
module tv_bcd_view
  import tv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bcd_en_i,
  input  logic [1:0]        rd_addr_i,
  output logic [15:0]       rd_data_o,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [15:0]       wr_data_i,
  input  logic [4:0]        hour_i,
  input  logic [5:0]        min_i,
  input  logic [5:0]        sec_i,
  input  logic [4:0]        day_i,
  output logic              upd_hm_o,
  output logic              upd_sec_o,
  output logic              upd_day_o,
  output logic [4:0]        new_hour_o,
  output logic [5:0]        new_min_o,
  output logic [5:0]        new_sec_o,
  output logic [4:0]        new_day_o
);
  tv_rd_view u_rd (
    .bcd_en_i (bcd_en_i),
    .rd_addr_i(rd_addr_i),
    .hour_i   (hour_i),
    .min_i    (min_i),
    .sec_i    (sec_i),
    .day_i    (day_i),
    .rd_data_o(rd_data_o)
  );

  tv_wr_path u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bcd_en_i  (bcd_en_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .upd_hm_o  (upd_hm_o),
    .upd_sec_o (upd_sec_o),
    .upd_day_o (upd_day_o),
    .new_hour_o(new_hour_o),
    .new_min_o (new_min_o),
    .new_sec_o (new_sec_o),
    .new_day_o (new_day_o)
  );
endmodule

// File: rtl/tv_bcd_view_chk.sv
`timescale 1ns/1ps
module tv_bcd_view_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bcd_en_i,
  input logic [1:0]  rd_addr_i,
  input logic [15:0] rd_data_o,
  input logic        wr_en_i,
  input logic [1:0]  wr_addr_i,
  input logic        upd_hm_o,
  input logic        upd_sec_o,
  input logic        upd_day_o,
  input logic [4:0]  new_hour_o,
  input logic [5:0]  new_min_o,
  input logic [5:0]  new_sec_o,
  input logic [4:0]  new_day_o
);
  logic upd_any;
  assign upd_any = upd_hm_o | upd_sec_o | upd_day_o;

  assert_single_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({upd_hm_o, upd_sec_o, upd_day_o}));

  assert_strobe_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_any |-> $past(wr_en_i));

  assert_hm_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_hm_o |-> ($past(wr_addr_i) == 2'd0));

  assert_sec_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_sec_o |-> ($past(wr_addr_i) == 2'd1));

  assert_day_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_day_o |-> ($past(wr_addr_i) == 2'd2));

  assert_rsvd_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd3) |=> !upd_any);

  assert_hm_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_hm_o |-> (new_hour_o <= 5'd23 && new_min_o <= 6'd59));

  assert_sec_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_sec_o |-> (new_sec_o <= 6'd59));

  assert_day_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_day_o |-> (new_day_o != 5'd0));

  assert_hold_hm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_hm_o |-> ($stable(new_hour_o) && $stable(new_min_o)));

  assert_bin_pad_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bcd_en_i && rd_addr_i == 2'd0) |-> (rd_data_o[15:13] == 3'd0 && rd_data_o[7:6] == 2'd0));

  assert_bcd_digits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_en_i |-> (rd_data_o[15:12] <= 4'd9 && rd_data_o[11:8] <= 4'd9 &&
                  rd_data_o[7:4] <= 4'd9 && rd_data_o[3:0] <= 4'd9));
endmodule

bind tv_bcd_view tv_bcd_view_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bcd_en_i  (bcd_en_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .upd_hm_o  (upd_hm_o),
  .upd_sec_o (upd_sec_o),
  .upd_day_o (upd_day_o),
  .new_hour_o(new_hour_o),
  .new_min_o (new_min_o),
  .new_sec_o (new_sec_o),
  .new_day_o (new_day_o)
);

// File: tb/sim_tv_bcd_view.sv
`timescale 1ns/1ps
module sim_tv_bcd_view;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bcd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  hour = 5'd13;
  logic [5:0]  min = 6'd45;
  logic [5:0]  sec = 6'd37;
  logic [4:0]  day = 5'd29;
  logic        upd_hm, upd_sec, upd_day;
  logic [4:0]  new_hour, new_day;
  logic [5:0]  new_min, new_sec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tv_bcd_view u0 (
    .clk_i(clk), .rst_ni(rst_n), .bcd_en_i(bcd_en),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hour_i(hour), .min_i(min), .sec_i(sec), .day_i(day),
    .upd_hm_o(upd_hm), .upd_sec_o(upd_sec), .upd_day_o(upd_day),
    .new_hour_o(new_hour), .new_min_o(new_min), .new_sec_o(new_sec), .new_day_o(new_day)
  );

  // wr, bcd, addr, data, accept, expected (read data, or repacked binary result), requirement number
  typedef struct packed {
    logic        wr;
    logic        bcd;
    logic [1:0]  addr;
    logic [15:0] data;
    logic        ok;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    // reads with hour=13 min=45 sec=37 day=29
    '{1'b0, 1'b0, 2'd0, 16'h0000, 1'b1, 16'h0D2D, 8'd2},  // R2
    '{1'b0, 1'b1, 2'd0, 16'h0000, 1'b1, 16'h1345, 8'd3},  // R3
    '{1'b0, 1'b0, 2'd1, 16'h0000, 1'b1, 16'h0025, 8'd4},  // R4
    '{1'b0, 1'b1, 2'd1, 16'h0000, 1'b1, 16'h0037, 8'd4},  // R4
    '{1'b0, 1'b0, 2'd2, 16'h0000, 1'b1, 16'h001D, 8'd4},  // R4
    '{1'b0, 1'b1, 2'd2, 16'h0000, 1'b1, 16'h0029, 8'd4},  // R4
    '{1'b0, 1'b0, 2'd3, 16'h0000, 1'b1, 16'h0000, 8'd10}, // R10
    '{1'b0, 1'b1, 2'd3, 16'h0000, 1'b1, 16'h0000, 8'd10}, // R10
    // writes
    '{1'b1, 1'b1, 2'd0, 16'h2359, 1'b1, 16'h173B, 8'd6},  // R6
    '{1'b1, 1'b1, 2'd0, 16'h0000, 1'b1, 16'h0000, 8'd6},  // R6
    '{1'b1, 1'b1, 2'd0, 16'h1A30, 1'b0, 16'h0000, 8'd8},  // R8
    '{1'b1, 1'b1, 2'd0, 16'h2400, 1'b0, 16'h0000, 8'd9},  // R9
    '{1'b1, 1'b1, 2'd0, 16'h0960, 1'b0, 16'h0000, 8'd9},  // R9
    '{1'b1, 1'b0, 2'd0, 16'hE5D7, 1'b1, 16'h0517, 8'd7},  // R7
    '{1'b1, 1'b0, 2'd0, 16'h1800, 1'b0, 16'h0000, 8'd9},  // R9
    '{1'b1, 1'b1, 2'd1, 16'h0045, 1'b1, 16'h002D, 8'd6},  // R6
    '{1'b1, 1'b1, 2'd1, 16'h005F, 1'b0, 16'h0000, 8'd8},  // R8
    '{1'b1, 1'b0, 2'd1, 16'hFFFB, 1'b1, 16'h003B, 8'd7},  // R7
    '{1'b1, 1'b0, 2'd1, 16'h003C, 1'b0, 16'h0000, 8'd9},  // R9
    '{1'b1, 1'b1, 2'd2, 16'h0031, 1'b1, 16'h001F, 8'd6},  // R6
    '{1'b1, 1'b1, 2'd2, 16'h0000, 1'b0, 16'h0000, 8'd9},  // R9
    '{1'b1, 1'b0, 2'd2, 16'h0020, 1'b0, 16'h0000, 8'd7},  // R7: masked to 0, rejected
    '{1'b1, 1'b1, 2'd2, 16'h0032, 1'b0, 16'h0000, 8'd9},  // R9
    '{1'b1, 1'b1, 2'd3, 16'h0001, 1'b0, 16'h0000, 8'd10}  // R10
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] result(input logic [1:0] a);
    case (a)
      2'd0:    return {3'b0, new_hour, 2'b0, new_min};
      2'd1:    return {10'b0, new_sec};
      2'd2:    return {11'b0, new_day};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [2:0] strobe_exp(input logic ok, input logic [1:0] a);
    if (!ok || a == 2'd3) return 3'b000;
    return 3'(1 << a);
  endfunction

  logic [15:0] held;

  initial begin
    // R1: reset state
    #12;
    chk("R1 strobes in reset", {13'b0, upd_day, upd_sec, upd_hm}, 16'h0000);
    chk("R1 values in reset", {new_hour, new_min, new_day}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 strobes after reset", {13'b0, upd_day, upd_sec, upd_hm}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      @(negedge clk);
      bcd_en = VECS[i].bcd;
      if (!VECS[i].wr) begin
        rd_addr = VECS[i].addr;
        #1;
        chk(tag, rd_data, VECS[i].exp);
      end else begin
        held = result(VECS[i].addr);
        wr_en = 1'b1;
        wr_addr = VECS[i].addr;
        wr_data = VECS[i].data;
        @(negedge clk);
        wr_en = 1'b0;
        chk({tag, " strobe"}, {13'b0, upd_day, upd_sec, upd_hm},
            {13'b0, strobe_exp(VECS[i].ok, VECS[i].addr)});
        if (VECS[i].ok) chk({tag, " value"}, result(VECS[i].addr), VECS[i].exp);
        else chk({tag, " held"}, result(VECS[i].addr), held);
      end
    end

    // R11: single write gives a one-cycle strobe
    @(negedge clk);
    bcd_en = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h0012;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 strobe high", {15'b0, upd_sec}, 16'h0001);
    @(negedge clk);
    chk("R11 strobe one cycle", {13'b0, upd_day, upd_sec, upd_hm}, 16'h0000);

    // R5: read follows inputs with no clock edge
    bcd_en = 1'b0; rd_addr = 2'd0; hour = 5'd7; min = 6'd45;
    #1;
    chk("R5 binary same cycle", rd_data, 16'h072D);
    bcd_en = 1'b1;
    #1;
    chk("R5 format switch same cycle", rd_data, 16'h0745);

    // R3 corners
    hour = 5'd0; min = 6'd0;
    #1;
    chk("R3 zero", rd_data, 16'h0000);
    hour = 5'd23; min = 6'd59;
    #1;
    chk("R3 max", rd_data, 16'h2359);

    // read and write on the same register in one cycle
    @(negedge clk);
    hour = 5'd13; min = 6'd45; bcd_en = 1'b1; rd_addr = 2'd0;
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0815;
    #1;
    chk("R5 read during write", rd_data, 16'h1345);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6 strobe after overlap", {15'b0, upd_hm}, 16'h0001);
    chk("R6 value after overlap", result(2'd0), 16'h080F);
    // same data word, binary format in force
    @(negedge clk);
    bcd_en = 1'b0; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0815;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 binary decode of same word", result(2'd0), 16'h0815);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule